// File: doc/BRIEF.md
# Fractional-Step Nanosecond Time Counter

This block keeps a running time of day in nanoseconds for a packet timestamping path. Every core clock cycle, while the counter is switched on, a software-programmed step is added to a wide accumulator. The step is a 32.32 fixed-point count of nanoseconds, so software can trim the counter's rate below one part per billion by nudging the fractional half of the step. It does not need to touch the clock itself.

Software reaches the block through a small word-wide register port with separate read and write strobes. There is a control word with a run bit, a step register, and two time read-back words: the integer nanoseconds and the fraction. A read of the integer word captures the fraction at that same instant, so the two halves read one after the other describe one point in time. The block also reports the core clock rate in Hz, worked out from a multiplier field of a boot word, so that software can compute the nominal step as (10^9 · 2^32) / rate.

Top module: `ptp_time_counter`

## Requirements
- R1: After reset the run bit, the step, the accumulator, the captured fraction and `rdData` are all zero.
- R2: Offset 0xF00 is the control word. Bit 0 of a write sets the run bit. A read returns the run bit in bit 0 and zeros elsewhere.
- R3: Offset 0xF18 holds the step: bits 63:32 are whole nanoseconds and bits 31:0 are the fraction. A read returns the value last written.
- R4: On each clock edge with the run bit set, the step is added to a 96-bit accumulator (64 integer bits above 32 fraction bits). The carry out of the fraction is exact. A read of offset 0xF10 returns the integer bits and wraps modulo 2^64.
- R5: While the run bit is clear, the accumulator does not move. Clearing the run bit leaves both the time and the step as they were.
- R6: A step write takes effect from the edge after the write. The add on the write edge itself still uses the old step.
- R7: A read of 0xF10 captures the 32 fraction bits from that same instant. A later read of 0xF08 returns those captured bits zero-extended, even if the counter has moved on since.
- R8: Reads of any other offset return zero. Writes to any other offset, and to 0xF08 or 0xF10, change nothing.
- R9: `rateHz` equals 50,000,000 times bits 38:33 of `bootWord` when `bootValid` is high, and 800,000,000 (a multiplier of 16) when it is low.
- R10: `rdData` is updated on the clock edge at which `rdEn` is sampled high. It holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 12 | Register byte offset |
| wrData | input | 64 | Write data |
| rdData | output | 64 | Read data, registered |
| bootWord | input | 64 | Boot word carrying the clock multiplier |
| bootValid | input | 1 | High when `bootWord` is available |
| rateHz | output | 40 | Derived core clock rate in Hz |

## Verification
The assertions assume that `wrEn` and `rdEn` are single-cycle strobes and that `addr` is stable in any cycle in which either strobe is high. They also assume that reset is held for at least one edge before any access. The bench drives every input at the falling edge and raises a strobe for exactly one edge per access. It never issues a read and a write in the same cycle. The only input it changes with the counter running is the step, and it does so deliberately to test the next-edge rule.

// File: rtl/ptp_tc_pkg.sv
package ptp_tc_pkg;

  localparam int OFS_W = 12;
  localparam logic [OFS_W-1:0] OFS_CTRL    = 12'hF00;
  localparam logic [OFS_W-1:0] OFS_TIME_LO = 12'hF08;
  localparam logic [OFS_W-1:0] OFS_TIME_HI = 12'hF10;
  localparam logic [OFS_W-1:0] OFS_STEP    = 12'hF18;

  typedef enum logic [2:0] {
    RD_HOLD = 3'd0,
    RD_ZERO = 3'd1,
    RD_CTRL = 3'd2,
    RD_STEP = 3'd3,
    RD_HI   = 3'd4,
    RD_LO   = 3'd5
  } rdSel_e;

  typedef struct packed {
    logic   runOn;
    logic   stepWr;
    logic   capHi;
    rdSel_e rdSel;
  } strobe_t;

endpackage

// File: rtl/ptp_tc_ctrl.sv
module ptp_tc_ctrl
  import ptp_tc_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int BOOT_W   = 64,
  parameter int MUL_LSB  = 33,
  parameter int MUL_W    = 6,
  parameter int DFLT_MUL = 16,
  parameter longint BASE_HZ = 50_000_000,
  parameter int RATE_W   = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrBit0,
  input  logic [BOOT_W-1:0] bootWord,
  input  logic              bootValid,
  output strobe_t           stb,
  output logic [RATE_W-1:0] rateHz
);

  localparam int MUL_HI = MUL_LSB + MUL_W;

  logic runQ;
  logic ctrlWr;
  logic [MUL_W-1:0] mulSel;
  logic unusedBoot;

  assign ctrlWr = wrEn && (addr == ADDR_W'(OFS_CTRL));

  always_ff @(posedge clk) begin
    if (!rstN) runQ <= 1'b0;
    else if (ctrlWr) runQ <= wrBit0;
  end

  always_comb begin
    stb.runOn  = runQ;
    stb.stepWr = wrEn && (addr == ADDR_W'(OFS_STEP));
    stb.capHi  = rdEn && (addr == ADDR_W'(OFS_TIME_HI));
    stb.rdSel  = RD_HOLD;
    if (rdEn) begin
      case (addr)
        ADDR_W'(OFS_CTRL):    stb.rdSel = RD_CTRL;
        ADDR_W'(OFS_STEP):    stb.rdSel = RD_STEP;
        ADDR_W'(OFS_TIME_HI): stb.rdSel = RD_HI;
        ADDR_W'(OFS_TIME_LO): stb.rdSel = RD_LO;
        default:              stb.rdSel = RD_ZERO;
      endcase
    end
  end

  // Rate derivation: multiplier field of the boot word, or a fixed fallback.
  assign mulSel = bootValid ? bootWord[MUL_LSB +: MUL_W] : MUL_W'(DFLT_MUL);
  assign rateHz = RATE_W'(BASE_HZ) * RATE_W'(mulSel);

  generate
    if (MUL_HI < BOOT_W) begin : g_upper
      assign unusedBoot = ^{bootWord[BOOT_W-1:MUL_HI], bootWord[MUL_LSB-1:0]};
    end else begin : g_noUpper
      assign unusedBoot = ^bootWord[MUL_LSB-1:0];
    end
  endgenerate

  // The run bit only changes through a write to the control word.
  assert_run_only_by_ctrl_R2 : assert property (@(posedge clk) disable iff (!rstN)
    !ctrlWr |=> $stable(runQ));

  assert_run_tracks_write_R2 : assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr |=> (runQ == $past(wrBit0)));

endmodule

// File: rtl/ptp_tc_datapath.sv
module ptp_tc_datapath
  import ptp_tc_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int INT_W  = 64,
  parameter int FRAC_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  localparam int ACC_W = INT_W + FRAC_W;

  logic [DATA_W-1:0] stepQ;
  logic [ACC_W-1:0]  accQ;
  logic [FRAC_W-1:0] capFracQ;

  always_ff @(posedge clk) begin
    if (!rstN) stepQ <= '0;
    else if (stb.stepWr) stepQ <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) accQ <= '0;
    else if (stb.runOn) accQ <= accQ + ACC_W'(stepQ);
  end

  always_ff @(posedge clk) begin
    if (!rstN) capFracQ <= '0;
    else if (stb.capHi) capFracQ <= accQ[FRAC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else begin
      case (stb.rdSel)
        RD_HOLD: rdData <= rdData;
        RD_CTRL: rdData <= DATA_W'(stb.runOn);
        RD_STEP: rdData <= stepQ;
        RD_HI:   rdData <= DATA_W'(accQ[ACC_W-1:FRAC_W]);
        RD_LO:   rdData <= DATA_W'(capFracQ);
        default: rdData <= '0;
      endcase
    end
  end

  assert_frozen_when_off_R5 : assert property (@(posedge clk) disable iff (!rstN)
    !stb.runOn |=> $stable(accQ));

  assert_step_only_by_write_R6 : assert property (@(posedge clk) disable iff (!rstN)
    !stb.stepWr |=> $stable(stepQ));

  assert_capture_only_on_hi_R7 : assert property (@(posedge clk) disable iff (!rstN)
    !stb.capHi |=> $stable(capFracQ));

  assert_unmapped_read_zero_R8 : assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdSel == RD_ZERO) |=> (rdData == '0));

  assert_rd_held_R10 : assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdSel == RD_HOLD) |=> $stable(rdData));

endmodule

// File: rtl/ptp_time_counter.sv
module ptp_time_counter
  import ptp_tc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 64,
  parameter int FRAC_W = 32,
  parameter int BOOT_W = 64,
  parameter int RATE_W = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [BOOT_W-1:0] bootWord,
  input  logic              bootValid,
  output logic [RATE_W-1:0] rateHz
);

  strobe_t stb;

  ptp_tc_ctrl #(
    .ADDR_W (ADDR_W),
    .BOOT_W (BOOT_W),
    .RATE_W (RATE_W)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .rdEn      (rdEn),
    .addr      (addr),
    .wrBit0    (wrData[0]),
    .bootWord  (bootWord),
    .bootValid (bootValid),
    .stb       (stb),
    .rateHz    (rateHz)
  );

  ptp_tc_datapath #(
    .DATA_W (DATA_W),
    .INT_W  (DATA_W),
    .FRAC_W (FRAC_W)
  ) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .wrData (wrData),
    .rdData (rdData)
  );

endmodule

// File: tb/sim_ptp_time_counter.sv
module sim_ptp_time_counter;

  localparam logic [11:0] A_CTRL = 12'hF00;
  localparam logic [11:0] A_LO   = 12'hF08;
  localparam logic [11:0] A_HI   = 12'hF10;
  localparam logic [11:0] A_STEP = 12'hF18;
  localparam logic [11:0] A_NONE = 12'hF20;

  typedef struct packed {
    logic [63:0] step;
    logic [7:0]  idle;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{step: 64'h0000_0001_4000_0000, idle: 8'd5},
    '{step: 64'h0000_0001_8000_0000, idle: 8'd3},
    '{step: 64'h0000_0000_5555_5555, idle: 8'd7},
    '{step: 64'h0000_0014_0000_0000, idle: 8'd10},
    '{step: 64'hFFFF_FFFF_FFFF_FFFF, idle: 8'd2}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [11:0] addr = '0;
  logic [63:0] wrData = '0;
  logic [63:0] rdData;
  logic [63:0] bootWord = '0;
  logic        bootValid = 1'b0;
  logic [39:0] rateHz;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;
  logic [95:0] mAcc = '0;
  logic [63:0] got;

  always #10 clk = ~clk;

  ptp_time_counter u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .bootWord(bootWord),
    .bootValid(bootValid), .rateHz(rateHz)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(posedge clk); @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [63:0] d);
    rdEn = 1'b1; addr = a;
    @(posedge clk); @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  initial begin
    logic [95:0] snap;
    logic [63:0] lastStep;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    check("R1 rdData", rdData, 64'd0);
    rd(A_HI, got);   check("R1 time", got, 64'd0);
    rd(A_LO, got);   check("R1 fraction", got, 64'd0);
    rd(A_CTRL, got); check("R1 run bit", got, 64'd0);
    rd(A_STEP, got); check("R1 step", got, 64'd0);

    // R9 rate derivation
    bootValid = 1'b0; #1;
    check("R9 fallback rate", 64'(rateHz), 64'd800_000_000);
    bootValid = 1'b1; bootWord = 64'(20) << 33 | 64'h1_FFFF_FFFF; #1;
    check("R9 multiplier 20", 64'(rateHz), 64'd1_000_000_000);
    bootWord = 64'(63) << 33; #1;
    check("R9 multiplier 63", 64'(rateHz), 64'd3_150_000_000);

    // R3/R4 vector table
    lastStep = '0;
    foreach (VECS[i]) begin
      wr(A_STEP, VECS[i].step);
      wr(A_CTRL, 64'd1);
      idle(int'(VECS[i].idle));
      wr(A_CTRL, 64'd0);
      mAcc = mAcc + 96'(int'(VECS[i].idle) + 1) * 96'(VECS[i].step);
      rd(A_HI, got);   check("R4 integer time", got, mAcc[95:32]);
      rd(A_LO, got);   check("R4 fraction carry", got, 64'(mAcc[31:0]));
      rd(A_STEP, got); check("R3 step readback", got, VECS[i].step);
      lastStep = VECS[i].step;
    end

    // R5 frozen while off
    idle(5);
    rd(A_HI, got);   check("R5 time frozen", got, mAcc[95:32]);
    rd(A_STEP, got); check("R5 step kept", got, lastStep);

    // R6 step change applies from the next edge
    wr(A_STEP, 64'h2_0000_0000);
    wr(A_CTRL, 64'd1);
    wr(A_STEP, 64'h3_0000_0000);
    idle(2);
    wr(A_CTRL, 64'd0);
    mAcc = mAcc + 96'h2_0000_0000 + 96'd3 * 96'h3_0000_0000;
    rd(A_HI, got); check("R6 old step on write edge", got, mAcc[95:32]);

    // R7 capture of the fraction on the integer read
    wr(A_STEP, 64'h1_8000_0000);
    wr(A_CTRL, 64'd1);
    idle(3);
    snap = mAcc + 96'd3 * 96'h1_8000_0000;
    rd(A_HI, got); check("R7 integer at capture", got, snap[95:32]);
    idle(2);
    wr(A_CTRL, 64'd0);
    mAcc = mAcc + 96'd7 * 96'h1_8000_0000;
    rd(A_LO, got); check("R7 captured fraction", got, 64'(snap[31:0]));
    rd(A_HI, got); check("R7 integer after run", got, mAcc[95:32]);

    // R8 unmapped and read-only offsets
    rd(A_NONE, got); check("R8 unmapped read", got, 64'd0);
    wr(A_NONE, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(A_HI, 64'h123);
    wr(A_LO, 64'h55);
    rd(A_CTRL, got); check("R8 run bit untouched", got, 64'd0);
    rd(A_STEP, got); check("R8 step untouched", got, 64'h1_8000_0000);
    rd(A_HI, got);   check("R8 time untouched", got, mAcc[95:32]);

    // R10 read data held
    idle(3);
    check("R10 rdData held", rdData, mAcc[95:32]);

    // R2 control word readback
    wr(A_CTRL, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(A_CTRL, got); check("R2 run bit set", got, 64'd1);
    wr(A_CTRL, 64'hFFFF_FFFF_FFFF_FFFE);
    mAcc = mAcc + 96'd2 * 96'h1_8000_0000;
    rd(A_CTRL, got); check("R2 run bit clear", got, 64'd0);
    rd(A_HI, got);   check("R2 time after toggle", got, mAcc[95:32]);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule